// File: doc/BRIEF.md
# Masked BCD Digit-Serial Arithmetic Unit

This unit holds three working registers, each eleven binary-coded decimal digits wide, and runs decimal arithmetic on them one digit per clock. A 4-bit span code picks a contiguous range of digits for the operation. Digits outside that range keep their value. The same code also supplies a one-digit immediate constant. The unit steps through the selected digits by itself, starting at the lowest and ending at the highest. A one-bit ripple register carries the carry or borrow from one digit to the next.

The surrounding sequencer presents an already decoded operation with these fields:
- two source selects;
- a destination select;
- the span code;
- a start strobe.

It then waits for a one-cycle `done` pulse. Completion also leaves a single condition bit, which holds the final carry or borrow of the span. A direct write port lets other logic place a whole register value while the unit is idle.

Top module: `bcd_mask_alu`

## Requirements
- R1: After reset all three registers read zero, and `cond`, `busy` and `done` are 0.
- R2: When `busy` is 0, asserting `wrEn` stores `wrData` into the register picked by `wrSel` (0=A, 1=B, 2=C; 3 stores nothing). While `busy` is 1, `wrEn` has no effect on any register.
- R3: The unit accepts `start` only when `busy` is 0. Starting from the next cycle, `busy` stays high for exactly as many cycles as the span has digits. `done` is high for one cycle, in the first cycle after `busy` falls. A `start` given while `busy` is 1 is ignored.
- R4: The span code gives (lowest digit, highest digit, constant), with digit 0 the least significant:
  - 0=(0,0,1), 1=(0,0,5), 2=(0,0,7), 3=(1,1,4);
  - 4=(2,2,1), 5=(0,1,1), 6=(9,10,0), 7=(10,10,1);
  - 8=(0,8,1), 9=(9,9,1), 10=(0,2,3), 11=(3,5,2);
  - 12=(5,10,1), 13=(1,8,9), 14=(0,10,1), 15=(0,10,0).
  
  Digits of the destination outside the span are left unchanged.
- R5: `opSel`=0 (add) writes the decimal sum of the X and Y span values, modulo 10^n for an n-digit span. `cond` is set to the carry out of the top span digit.
- R6: `opSel`=1 (subtract) writes X−Y modulo 10^n. `cond` is set to the borrow out of the top span digit, which is 1 exactly when X<Y.
- R7: `opSel`=2 (add constant) and `opSel`=3 (subtract constant) behave like add and subtract. The Y operand is replaced by the constant placed at the lowest span digit, with zeros in the rest of the span.
- R8: `opSel`=4 (load constant) writes the constant into the lowest span digit and zero into the other span digits. `cond` becomes 0.
- R9: `opSel`=5 (compare) changes no register. `cond` becomes 1 exactly when the X span value is less than the Y span value.
- R10: `opSel`=6 shifts the X span one digit toward the most significant end, and `opSel`=7 shifts it one digit toward the least significant end. The result goes to the destination. A zero enters at the vacated end, the digit pushed out is lost, and `cond` becomes 0.
- R11: Source select value 3 reads as all zeros. Destination select value 3 discards the result and leaves every register unchanged.
- R12: `cond` changes only at the clock edge that ends an operation. It holds its value in every cycle in which `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation described by the operation fields |
| opSel | input | 3 | Operation code (see R5–R10) |
| srcX | input | 2 | First operand register select |
| srcY | input | 2 | Second operand register select |
| dstSel | input | 2 | Destination register select |
| maskCode | input | 4 | Span and constant code (see R4) |
| wrEn | input | 1 | Direct whole-register write enable |
| wrSel | input | 2 | Direct write register select |
| wrData | input | 44 | Direct write data, eleven BCD digits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cond | output | 1 | Condition bit of the last operation |
| regA | output | 44 | Register A contents |
| regB | output | 44 | Register B contents |
| regC | output | 44 | Register C contents |

## Verification
Two functions can land in the same cycle:
- the final digit step of an operation, and a direct register write or a fresh `start` arriving while the unit still reports `busy`;
- the read of a digit and the write of a neighbouring digit of the same register, during shifts where source and destination coincide.

The bench provokes the first case on many runs by raising `wrEn` with garbage data and a second `start` in the first busy cycle. Because single-digit spans are included, that cycle is also the final step of the operation. The second case arises because every source/destination pairing appears in the sweep. Both are judged by comparing all three registers and `cond` against a decimal model of the span values, computed with integer arithmetic.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;

  localparam int NUM_DIGITS = 11;
  localparam int DIGIT_W    = 4;
  localparam int REG_W      = NUM_DIGITS * DIGIT_W;
  localparam int IDX_W      = $clog2(NUM_DIGITS);

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDK = 3'd2,
    OP_SUBK = 3'd3,
    OP_LDK  = 3'd4,
    OP_CMP  = 3'd5,
    OP_SHL  = 3'd6,
    OP_SHR  = 3'd7
  } aluOp_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latch;  // capture operation fields
    logic step;   // process the digit at the current index
    logic first;  // current index is the lowest span digit
    logic last;   // current index is the highest span digit
  } ctrlStrobe_t;

endpackage

// File: rtl/bcd_mask_rom.sv
module bcd_mask_rom #(
  parameter int NUM_DIGITS = 11,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic [3:0]       code,
  output logic [IDX_W-1:0] spanLo,
  output logic [IDX_W-1:0] spanHi,
  output logic [3:0]       kDigit
);

  localparam int TOP = NUM_DIGITS - 1;

  int lo, hi;

  always_comb begin
    lo     = 0;
    hi     = TOP;
    kDigit = 4'd0;
    case (code)
      4'd0:  begin lo = 0;       hi = 0;       kDigit = 4'd1; end
      4'd1:  begin lo = 0;       hi = 0;       kDigit = 4'd5; end
      4'd2:  begin lo = 0;       hi = 0;       kDigit = 4'd7; end
      4'd3:  begin lo = 1;       hi = 1;       kDigit = 4'd4; end
      4'd4:  begin lo = 2;       hi = 2;       kDigit = 4'd1; end
      4'd5:  begin lo = 0;       hi = 1;       kDigit = 4'd1; end
      4'd6:  begin lo = TOP - 1; hi = TOP;     kDigit = 4'd0; end
      4'd7:  begin lo = TOP;     hi = TOP;     kDigit = 4'd1; end
      4'd8:  begin lo = 0;       hi = TOP - 2; kDigit = 4'd1; end
      4'd9:  begin lo = TOP - 1; hi = TOP - 1; kDigit = 4'd1; end
      4'd10: begin lo = 0;       hi = 2;       kDigit = 4'd3; end
      4'd11: begin lo = 3;       hi = 5;       kDigit = 4'd2; end
      4'd12: begin lo = 5;       hi = TOP;     kDigit = 4'd1; end
      4'd13: begin lo = 1;       hi = TOP - 2; kDigit = 4'd9; end
      4'd14: begin lo = 0;       hi = TOP;     kDigit = 4'd1; end
      default: begin lo = 0;     hi = TOP;     kDigit = 4'd0; end
    endcase
    // keep spans legal for small digit counts
    if (hi > TOP) hi = TOP;
    if (hi < 0)   hi = 0;
    if (lo > hi)  lo = hi;
    if (lo < 0)   lo = 0;
  end

  assign spanLo = IDX_W'(lo);
  assign spanHi = IDX_W'(hi);

endmodule

// File: rtl/bcd_alu_ctrl.sv
module bcd_alu_ctrl
  import bcd_alu_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] spanLo,
  input  logic [IDX_W-1:0] spanHi,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] idx,
  output logic             busy,
  output logic             done
);

  logic [IDX_W-1:0] idxQ, loQ, hiQ;
  logic             busyQ, doneQ;

  always_comb begin
    strobe.latch = start && !busyQ;
    strobe.step  = busyQ;
    strobe.first = busyQ && (idxQ == loQ);
    strobe.last  = busyQ && (idxQ == hiQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ  <= '0;
      loQ   <= '0;
      hiQ   <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobe.last;
      if (strobe.latch) begin
        busyQ <= 1'b1;
        idxQ  <= spanLo;
        loQ   <= spanLo;
        hiQ   <= spanHi;
      end else if (busyQ) begin
        if (idxQ == hiQ) busyQ <= 1'b0;
        else             idxQ  <= idxQ + 1'b1;
      end
    end
  end

  assign idx  = idxQ;
  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/bcd_alu_dpath.sv
module bcd_alu_dpath
  import bcd_alu_pkg::*;
#(
  parameter int NUM_DIGITS = 11,
  parameter int DIGIT_W    = 4,
  parameter int IDX_W      = $clog2(NUM_DIGITS)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [IDX_W-1:0]              idx,
  input  logic [3:0]                    kDigit,
  input  logic [2:0]                    opSel,
  input  logic [1:0]                    srcX,
  input  logic [1:0]                    srcY,
  input  logic [1:0]                    dstSel,
  input  logic                          wrEn,
  input  logic [1:0]                    wrSel,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] wrData,
  output logic [NUM_DIGITS*DIGIT_W-1:0] regA,
  output logic [NUM_DIGITS*DIGIT_W-1:0] regB,
  output logic [NUM_DIGITS*DIGIT_W-1:0] regC,
  output logic                          cond
);

  localparam int RW       = NUM_DIGITS * DIGIT_W;
  localparam int NUM_REGS = 3;

  aluOp_e       opQ;
  logic [1:0]   xSelQ, ySelQ, dstQ;
  logic [3:0]   kQ;
  logic         chainQ, condQ;
  logic [DIGIT_W-1:0] prevQ;

  logic [RW-1:0] regFile [NUM_REGS];
  logic [RW-1:0] xReg, yReg;

  function automatic logic [RW-1:0] pickReg(input logic [1:0] sel,
                                            input logic [RW-1:0] r0,
                                            input logic [RW-1:0] r1,
                                            input logic [RW-1:0] r2);
    case (sel)
      2'd0:    return r0;
      2'd1:    return r1;
      2'd2:    return r2;
      default: return '0;
    endcase
  endfunction

  assign xReg = pickReg(xSelQ, regFile[0], regFile[1], regFile[2]);
  assign yReg = pickReg(ySelQ, regFile[0], regFile[1], regFile[2]);

  // digit-level operands
  logic [IDX_W-1:0]   nextIdx;
  logic [DIGIT_W-1:0] xDig, xNextDig, yDig, yOp, resDig;
  logic               carryIn, chainOut, writesBack, condVal;
  logic [DIGIT_W:0]   sumWide, diffWide;
  logic               addOver, subUnder;

  assign nextIdx  = strobe.last ? idx : idx + 1'b1;
  assign xDig     = xReg[idx * DIGIT_W +: DIGIT_W];
  assign xNextDig = xReg[nextIdx * DIGIT_W +: DIGIT_W];
  assign yDig     = yReg[idx * DIGIT_W +: DIGIT_W];
  assign carryIn  = strobe.first ? 1'b0 : chainQ;

  always_comb begin
    case (opQ)
      OP_ADDK, OP_SUBK: yOp = strobe.first ? DIGIT_W'(kQ) : '0;
      default:          yOp = yDig;
    endcase
    sumWide  = {1'b0, xDig} + {1'b0, yOp} + {{DIGIT_W{1'b0}}, carryIn};
    addOver  = sumWide > (DIGIT_W+1)'(9);
    diffWide = {1'b0, xDig} - {1'b0, yOp} - {{DIGIT_W{1'b0}}, carryIn};
    subUnder = diffWide[DIGIT_W];
  end

  always_comb begin
    resDig     = '0;
    chainOut   = 1'b0;
    writesBack = 1'b1;
    condVal    = 1'b0;
    case (opQ)
      OP_ADD, OP_ADDK: begin
        resDig   = addOver ? DIGIT_W'(sumWide + (DIGIT_W+1)'(6)) : sumWide[DIGIT_W-1:0];
        chainOut = addOver;
        condVal  = addOver;
      end
      OP_SUB, OP_SUBK: begin
        resDig   = subUnder ? DIGIT_W'(diffWide - (DIGIT_W+1)'(6)) : diffWide[DIGIT_W-1:0];
        chainOut = subUnder;
        condVal  = subUnder;
      end
      OP_CMP: begin
        writesBack = 1'b0;
        chainOut   = subUnder;
        condVal    = subUnder;
      end
      OP_LDK: resDig = strobe.first ? DIGIT_W'(kQ) : '0;
      OP_SHL: resDig = strobe.first ? '0 : prevQ;
      OP_SHR: resDig = strobe.last ? '0 : xNextDig;
      default: resDig = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ    <= OP_ADD;
      xSelQ  <= '0;
      ySelQ  <= '0;
      dstQ   <= '0;
      kQ     <= '0;
      chainQ <= 1'b0;
      prevQ  <= '0;
      condQ  <= 1'b0;
    end else begin
      if (strobe.latch) begin
        opQ   <= aluOp_e'(opSel);
        xSelQ <= srcX;
        ySelQ <= srcY;
        dstQ  <= dstSel;
        kQ    <= kDigit;
      end
      if (strobe.step) begin
        chainQ <= chainOut;
        prevQ  <= xDig;
        if (strobe.last) condQ <= condVal;
      end
    end
  end

  // one storage slice per register
  for (genvar r = 0; r < NUM_REGS; r++) begin : gReg
    logic [RW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (!strobe.step) begin
        if (wrEn && wrSel == 2'(r)) q <= wrData;
      end else if (writesBack && dstQ == 2'(r)) begin
        q[idx * DIGIT_W +: DIGIT_W] <= resDig;
      end
    end
    assign regFile[r] = q;
  end

  assign regA = regFile[0];
  assign regB = regFile[1];
  assign regC = regFile[2];
  assign cond = condQ;

endmodule

// File: rtl/bcd_mask_alu.sv
module bcd_mask_alu
  import bcd_alu_pkg::*;
#(
  parameter int NUM_DIGITS = bcd_alu_pkg::NUM_DIGITS,
  parameter int DIGIT_W    = bcd_alu_pkg::DIGIT_W,
  localparam int RW        = NUM_DIGITS * DIGIT_W,
  localparam int IW        = $clog2(NUM_DIGITS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    opSel,
  input  logic [1:0]    srcX,
  input  logic [1:0]    srcY,
  input  logic [1:0]    dstSel,
  input  logic [3:0]    maskCode,
  input  logic          wrEn,
  input  logic [1:0]    wrSel,
  input  logic [RW-1:0] wrData,
  output logic          busy,
  output logic          done,
  output logic          cond,
  output logic [RW-1:0] regA,
  output logic [RW-1:0] regB,
  output logic [RW-1:0] regC
);

  logic [IW-1:0] spanLo, spanHi, idx;
  logic [3:0]    kDigit;
  ctrlStrobe_t   strobe;

  bcd_mask_rom #(.NUM_DIGITS(NUM_DIGITS), .IDX_W(IW)) uRom (
    .code(maskCode), .spanLo(spanLo), .spanHi(spanHi), .kDigit(kDigit)
  );

  bcd_alu_ctrl #(.IDX_W(IW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .spanLo(spanLo), .spanHi(spanHi),
    .strobe(strobe), .idx(idx), .busy(busy), .done(done)
  );

  bcd_alu_dpath #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W), .IDX_W(IW)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .kDigit(kDigit),
    .opSel(opSel), .srcX(srcX), .srcY(srcY), .dstSel(dstSel),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .regA(regA), .regB(regB), .regC(regC), .cond(cond)
  );

endmodule

// File: rtl/bcd_mask_alu_chk.sv
module bcd_mask_alu_chk #(
  parameter int RW = 44
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          wrEn,
  input logic          busy,
  input logic          done,
  input logic          cond,
  input logic [RW-1:0] regA,
  input logic [RW-1:0] regB,
  input logic [RW-1:0] regC
);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && $past(busy));

  a_r3_start_taken: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);

  a_r12_cond_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(cond));

  a_r2_regs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !wrEn |=> $stable(regA) && $stable(regB) && $stable(regC));

endmodule

bind bcd_mask_alu bcd_mask_alu_chk #(.RW(RW)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .wrEn(wrEn), .busy(busy),
  .done(done), .cond(cond), .regA(regA), .regB(regB), .regC(regC)
);

// File: tb/tb_bcd_mask_alu.sv
module tb_bcd_mask_alu;

  localparam int ND = 11;
  localparam int RW = ND * 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    opSel = '0;
  logic [1:0]    srcX = '0, srcY = '0, dstSel = '0;
  logic [3:0]    maskCode = '0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = '0;
  logic [RW-1:0] wrData = '0;
  logic          busy, done, cond;
  logic [RW-1:0] regA, regB, regC;

  int checks = 0;
  int fails  = 0;
  logic [RW-1:0] model [3];
  logic          condModel = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bcd_mask_alu dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .srcX(srcX), .srcY(srcY),
    .dstSel(dstSel), .maskCode(maskCode), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .busy(busy), .done(done), .cond(cond), .regA(regA), .regB(regB), .regC(regC)
  );

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // span table for the eleven-digit default (R4)
  task automatic spanOf(input int code, output int lo, output int hi, output int k);
    case (code)
      0: begin lo = 0; hi = 0; k = 1; end
      1: begin lo = 0; hi = 0; k = 5; end
      2: begin lo = 0; hi = 0; k = 7; end
      3: begin lo = 1; hi = 1; k = 4; end
      4: begin lo = 2; hi = 2; k = 1; end
      5: begin lo = 0; hi = 1; k = 1; end
      6: begin lo = 9; hi = 10; k = 0; end
      7: begin lo = 10; hi = 10; k = 1; end
      8: begin lo = 0; hi = 8; k = 1; end
      9: begin lo = 9; hi = 9; k = 1; end
      10: begin lo = 0; hi = 2; k = 3; end
      11: begin lo = 3; hi = 5; k = 2; end
      12: begin lo = 5; hi = 10; k = 1; end
      13: begin lo = 1; hi = 8; k = 9; end
      14: begin lo = 0; hi = 10; k = 1; end
      default: begin lo = 0; hi = 10; k = 0; end
    endcase
  endtask

  function automatic longint spanVal(input logic [RW-1:0] v, input int lo, input int hi);
    longint acc = 0;
    for (int d = hi; d >= lo; d--) acc = acc * 10 + longint'(v[d*4 +: 4]);
    return acc;
  endfunction

  function automatic logic [RW-1:0] putSpan(input logic [RW-1:0] v, input int lo,
                                            input int hi, input longint val);
    logic [RW-1:0] r = v;
    longint t = val;
    for (int d = lo; d <= hi; d++) begin
      r[d*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [RW-1:0] getM(input int sel);
    return (sel < 3) ? model[sel] : '0;
  endfunction

  function automatic logic [RW-1:0] randBcd();
    logic [RW-1:0] v;
    for (int d = 0; d < ND; d++) v[d*4 +: 4] = 4'($urandom_range(9));
    return v;
  endfunction

  function automatic string reqOf(input int op);
    case (op)
      0: return "R5 R4 R11";
      1: return "R6 R4 R11";
      2, 3: return "R7 R4 R11";
      4: return "R8 R4 R11";
      5: return "R9 R11";
      default: return "R10 R4 R11";
    endcase
  endfunction

  task automatic directWrite(input int sel, input logic [RW-1:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
    if (sel < 3) model[sel] = val;
  endtask

  task automatic checkRegs(input string req);
    check(req, regA, model[0]);
    check(req, regB, model[1]);
    check(req, regC, model[2]);
  endtask

  task automatic runOp(input int op, input int xs, input int ys, input int ds,
                       input int code, input bit disturb);
    int lo, hi, k, n, cnt;
    longint pw, xv, yv, r;
    logic c;
    logic condBefore;
    spanOf(code, lo, hi, k);
    n = hi - lo + 1;
    pw = 1;
    for (int i = 0; i < n; i++) pw = pw * 10;
    xv = spanVal(getM(xs), lo, hi);
    yv = (op == 2 || op == 3) ? longint'(k) : spanVal(getM(ys), lo, hi);
    c = 1'b0;
    r = 0;
    case (op)
      0, 2: begin r = xv + yv; c = (r >= pw); r = r % pw; end
      1, 3, 5: begin c = (xv < yv); r = c ? xv - yv + pw : xv - yv; end
      4: r = longint'(k);
      6: r = (xv * 10) % pw;
      default: r = xv / 10;
    endcase
    @(negedge clk);
    condBefore = cond;
    opSel = 3'(op); srcX = 2'(xs); srcY = 2'(ys); dstSel = 2'(ds);
    maskCode = 4'(code); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (busy && cnt < 20) begin
      cnt++;
      check("R12", {43'd0, cond}, {43'd0, condBefore});
      if (disturb && cnt == 1) begin
        start = 1'b1; opSel = 3'(4); dstSel = 2'(xs % 3); maskCode = 4'd15;
        wrEn = 1'b1; wrSel = 2'($urandom_range(2)); wrData = {RW{1'b1}};
      end
      @(negedge clk);
      start = 1'b0;
      wrEn = 1'b0;
    end
    if (op != 5 && ds < 3) model[ds] = putSpan(model[ds], lo, hi, r);
    condModel = c;
    check("R3 busy length", RW'(cnt), RW'(n));
    check("R3 done pulse", {43'd0, done}, {43'd0, 1'b1});
    checkRegs(disturb ? "R2 R3 write/start ignored while busy" : reqOf(op));
    check(reqOf(op), {43'd0, cond}, {43'd0, condModel});
    @(negedge clk);
    check("R3 done width", {43'd0, done}, 44'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkRegs("R1");
    check("R1 cond/busy/done", {41'd0, cond, busy, done}, 44'd0);

    // R2 idle write and write to select 3
    directWrite(1, 44'h123_4567_8901);
    directWrite(3, 44'h999_9999_9999);
    checkRegs("R2");

    // R5 corner: 99..9 + 1 over the full span carries out
    directWrite(0, 44'h999_9999_9999);
    directWrite(2, 44'h000_0000_0001);
    runOp(0, 0, 2, 0, 14, 1'b0);
    // R6 corner: 0 - 1 borrows out, R8 load
    runOp(1, 0, 2, 1, 15, 1'b0);
    runOp(4, 0, 0, 2, 3, 1'b0);

    // sweep: every code, every operation, three operand patterns
    for (int code = 0; code < 16; code++) begin
      for (int op = 0; op < 8; op++) begin
        for (int t = 0; t < 3; t++) begin
          case (t)
            0: begin directWrite(0, {ND{4'h9}}); directWrite(1, {ND{4'h9}});
                     directWrite(2, randBcd()); end
            1: begin directWrite(0, '0); directWrite(1, {ND{4'h9}});
                     directWrite(2, randBcd()); end
            default: begin directWrite(0, randBcd()); directWrite(1, randBcd());
                           directWrite(2, randBcd()); end
          endcase
          runOp(op, $urandom_range(3), $urandom_range(3), $urandom_range(3),
                code, ((code + op + t) % 3) == 0);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule